// File: doc/BRIEF.md
# Programmable Beep Tone Generator

The block produces a square-wave audio tone from a free-running counter. The counter advances once every two system clocks. Software picks one counter bit through a select field and gates the tone with an enable bit. The pitch therefore depends on which bit is selected. A tone taken from a higher bit has a lower pitch.

A power-management sequencer can run the system clock at full, half or one-thirty-second rate. It reports the current rate on a two-bit input. The block then moves the tone to a lower counter bit, so the audible pitch stays the same and software does not rewrite the select field.

Software reaches two registers through a plain single-cycle write port and a combinational read port. The tone is registered and appears on a single output pin.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the tone output is low, and both registers read back as zero.
- R2: The enable register is at address 0, and bit 0 holds the enable. The other bits of a write are dropped, and they read back as zero.
- R3: The select register is at address 1, and its select field occupies bits 18:10. The other bits of a write are dropped, and they read back as zero, so writing all ones reads back 0x0007FC00.
- R4: The counter advances every second system clock. Field bit k selects counter bit 10+k. At full rate (rate code 0), field bit 0 gives a tone that toggles every 2048 clocks, a period of 4096 clocks.
- R5: At half rate (rate code 1), the selected counter bit index is reduced by 1. The half period for field bit 0 becomes 1024 clocks.
- R6: At one-thirty-second rate (rate code 2), the index is reduced by 5, and a result below zero is held at bit 0. Rate code 3 applies no reduction, like code 0.
- R7: A change of the rate input moves the tone to the compensated bit without any register write.
- R8: When several field bits are set, the lowest one is used. Field 0x006 selects counter bit 11, which toggles every 4096 clocks.
- R9: A field of zero keeps the tone low even when the block is enabled.
- R10: While the enable is clear, the tone stays low from the second clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Register address (0 = enable, 1 = select) |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Read data for reg_addr, reserved bits zero |
| rate_sel | input | 2 | Current clock rate: 0 full, 1 half, 2 one-thirty-second, 3 treated as full |
| tone_out | output | 1 | Registered tone output |

## Verification
The main function is exercised with a single field bit at each of the three rate codes and with the unused rate code. Comparing the measured half periods (2048, 1024, 64 and 2048 clocks) distinguishes a correct compensation shift from a missing or wrong one. A multi-bit field (0x006) and a higher single bit at the slow rate (0x008, which gives 512) separate lowest-bit priority from highest-bit priority and show that the shift applies to any base bit. Silence windows, taken with the enable clear and then with an empty field, separate the two ways the tone is gated.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_HALF = 2'd1,
    RATE_SLOW = 2'd2,
    RATE_RSVD = 2'd3
  } rate_e;
endpackage

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int FIELD_LO = 10,
  parameter int FIELD_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               beep_en,
  output logic [FIELD_W-1:0] sel_field
);
  localparam int FIELD_HI = FIELD_LO + FIELD_W - 1;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beep_en   <= 1'b0;
      sel_field <= '0;
    end else if (wr_en) begin
      if (addr == A_EN)  beep_en   <= wdata[0];
      if (addr == A_SEL) sel_field <= wdata[FIELD_HI:FIELD_LO];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_EN)  rdata[0] = beep_en;
    if (addr == A_SEL) rdata[FIELD_HI:FIELD_LO] = sel_field;
  end
endmodule

// File: rtl/beep_divider.sv
module beep_divider #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  logic phase;

  // Counter steps on every second system clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      phase <= ~phase;
      if (phase) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/beep_bitpick.sv
module beep_bitpick
  import beep_pkg::*;
#(
  parameter int FIELD_W    = 9,
  parameter int FIELD_LO   = 10,
  parameter int IDX_W      = 5,
  parameter int SHIFT_HALF = 1,
  parameter int SHIFT_SLOW = 5
) (
  input  logic [FIELD_W-1:0] field,
  input  rate_e              rate,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [FIELD_W-1:0] first_oh;
  logic [IDX_W-1:0]   low;
  logic [IDX_W-1:0]   base;
  logic [IDX_W-1:0]   shamt;

  // Isolate the lowest set field bit.
  genvar g;
  generate
    for (g = 0; g < FIELD_W; g++) begin : g_first
      if (g == 0) begin : g_lsb
        assign first_oh[g] = field[g];
      end else begin : g_up
        assign first_oh[g] = field[g] & ~(|field[g-1:0]);
      end
    end
  endgenerate

  assign hit = |field;

  always_comb begin
    low = '0;
    for (int i = 0; i < FIELD_W; i++) begin
      if (first_oh[i]) low = low | IDX_W'(i);
    end
    case (rate)
      RATE_HALF: shamt = IDX_W'(SHIFT_HALF);
      RATE_SLOW: shamt = IDX_W'(SHIFT_SLOW);
      default:   shamt = '0;
    endcase
    base = IDX_W'(FIELD_LO) + low;
    idx  = (base > shamt) ? (base - shamt) : '0;
  end
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int FIELD_LO   = 10,
  parameter int FIELD_W    = 9,
  parameter int SHIFT_HALF = 1,
  parameter int SHIFT_SLOW = 5,
  parameter int CNT_W      = FIELD_LO + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [1:0]        rate_sel,
  output logic              tone_out
);
  localparam int IDX_W = $clog2(CNT_W);

  logic               en_w;
  logic [FIELD_W-1:0] field_w;
  logic [CNT_W-1:0]   cnt_w;
  logic               hit_w;
  logic [IDX_W-1:0]   idx_w;
  logic               tone_q;

  beep_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_LO(FIELD_LO), .FIELD_W(FIELD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wr_data), .rdata(reg_rd_data), .beep_en(en_w), .sel_field(field_w)
  );

  beep_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_w)
  );

  beep_bitpick #(
    .FIELD_W(FIELD_W), .FIELD_LO(FIELD_LO), .IDX_W(IDX_W),
    .SHIFT_HALF(SHIFT_HALF), .SHIFT_SLOW(SHIFT_SLOW)
  ) u_pick (
    .field(field_w), .rate(rate_e'(rate_sel)), .hit(hit_w), .idx(idx_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tone_q <= 1'b0;
    else        tone_q <= en_w & hit_w & cnt_w[idx_w];
  end

  assign tone_out = tone_q;
endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int FIELD_LO   = 10,
  parameter int FIELD_W    = 9,
  parameter int CNT_W      = 19,
  parameter int IDX_W      = 5,
  parameter int SHIFT_SLOW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rd_data,
  input logic [1:0]         rate_sel,
  input logic               tone_out,
  input logic               beep_en,
  input logic [FIELD_W-1:0] sel_field,
  input logic [CNT_W-1:0]   cnt,
  input logic [IDX_W-1:0]   idx
);
  localparam logic [DATA_W-1:0] SEL_MASK =
    ((DATA_W'(1) << FIELD_W) - DATA_W'(1)) << FIELD_LO;
  localparam int SLOW_BIT = (FIELD_LO > SHIFT_SLOW) ? FIELD_LO - SHIFT_SLOW : 0;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !beep_en |=> !tone_out); // R10
  AST_EMPTY_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_field == '0) |=> !tone_out); // R9
  AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> (reg_rd_data[DATA_W-1:1] == '0)); // R2
  AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> ((reg_rd_data & ~SEL_MASK) == '0)); // R3
  AST_HALF_RATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |=> $stable(cnt)); // R4
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(CNT_W)); // R4
  AST_SLOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'd2 && sel_field[0]) |-> (idx == IDX_W'(SLOW_BIT))); // R6
endmodule

bind beep_tone_gen beep_tone_gen_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_LO(FIELD_LO), .FIELD_W(FIELD_W),
  .CNT_W(CNT_W), .IDX_W(IDX_W), .SHIFT_SLOW(SHIFT_SLOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd_data(reg_rd_data),
  .rate_sel(rate_sel), .tone_out(tone_out), .beep_en(en_w),
  .sel_field(field_w), .cnt(cnt_w), .idx(idx_w)
);

// File: tb/beep_tone_gen_bench.sv
`timescale 1ns/1ps
module beep_tone_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [1:0]  rate_sel = 2'd0;
  logic        tone_out;

  always #2.5 clk = ~clk;

  beep_tone_gen u_beep_tone_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .rate_sel(rate_sel), .tone_out(tone_out)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    edges = 0;
  int    last_edge = 0;
  bit    have_last = 0;
  logic  prev_tone = 1'b0;
  bit    done = 0;
  int    q_ival[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measures intervals between tone edges and pops expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (tone_out !== prev_tone) begin
        edges++;
        if (have_last && q_ival.size() > 0) begin
          int    e;
          string t;
          e = q_ival.pop_front();
          t = q_tag.pop_front();
          chk((cyc - last_edge) == e, t, cyc - last_edge, e);
        end
        last_edge = cyc;
        have_last = 1;
      end
      prev_tone = tone_out;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  // Driver: after a configuration change, skip two edges, then queue
  // the expected half periods for the monitor.
  task automatic expect_half(input int half, input int n, input string tag);
    int e0;
    e0 = edges;
    wait (edges >= e0 + 2);
    for (int i = 0; i < n; i++) begin
      q_ival.push_back(half);
      q_tag.push_back(tag);
    end
    wait (q_ival.size() == 0);
  endtask

  task automatic expect_silent(input int n, input string tag);
    int highs;
    highs = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_out !== 1'b0) highs++;
    end
    chk(highs == 0, tag, highs, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tone_out === 1'b0, "R1 tone after reset", int'(tone_out), 0);
    rd(2'd0, v); chk(v == 32'h0, "R1 enable reg after reset", int'(v), 0);
    rd(2'd1, v); chk(v == 32'h0, "R1 select reg after reset", int'(v), 0);

    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h1, "R2 enable readback", int'(v), 1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk(v == 32'h0007_FC00, "R3 select readback", int'(v), 32'h0007_FC00);

    wr(2'd1, 32'h0);
    expect_silent(5000, "R9 empty field silent");

    wr(2'd1, 32'h0000_0400);
    expect_half(2048, 3, "R4 full rate bit 10");

    rate_sel = 2'd1;
    expect_half(1024, 3, "R5 R7 half rate shift");
    rate_sel = 2'd2;
    expect_half(64, 3, "R6 R7 slow rate shift");
    rate_sel = 2'd3;
    expect_half(2048, 2, "R6 code 3 no shift");

    rate_sel = 2'd0;
    wr(2'd1, 32'h0000_1800);
    expect_half(4096, 2, "R8 lowest set bit");

    rate_sel = 2'd2;
    wr(2'd1, 32'h0000_2000);
    expect_half(512, 3, "R6 slow rate field bit 3");

    wr(2'd0, 32'h0);
    expect_silent(5000, "R10 disabled silent");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule